// File: doc/BRIEF.md
# Clock Synthesizer Retune Controller

This block reprograms a clock-synthesis primitive while the chip is running, so a change of waveform can bring its own processing clock with it. A one-cycle start request captures a multiplier and a divisor. The controller then holds the synthesizer in reset and writes one 16-bit word over the primitive's reconfiguration port, which has an address bus, a data bus, an enable strobe and a write strobe. It waits for the port to return ready, lets the synthesizer out of reset and waits for it to report lock. It signals completion with a single-cycle done pulse.

Each ratio is given as plain factor values; the controller stores each field as the factor minus one. From a 30.72 MHz reference, the pairs 8/1, 25/3 and 35/6 give the three processing clocks 245.76 MHz, 256 MHz and 179.2 MHz. Both waits are guarded by cycle limits. If the port never answers, or the synthesizer never locks, the controller raises an error flag and goes back to idle.

Top module: `clksynth_retune`

## Requirements
- R1: The written word is {mult_val-1, div_val-1} modulo 256 per field, with the multiplier field in bits [15:8] and the divisor field in bits [7:0]. It is captured when start is accepted and stays unchanged on prog_wdata while busy. prog_addr always equals CFG_ADDR.
- R2: A start sampled while idle makes busy and syn_rst high in the next cycle. While idle, syn_rst and prog_en are low.
- R3: prog_en and prog_we are high together for exactly one cycle per sequence. That cycle begins at the third clock edge after the edge that accepted start (RST_HOLD=3).
- R4: syn_rst is high for RST_HOLD cycles before the write strobe. It stays high through the strobe and until prog_rdy is sampled.
- R5: syn_rst goes low in the cycle after prog_rdy is sampled in the ready wait. A prog_rdy that arrives while the controller is idle has no effect.
- R6: syn_locked sampled high in the lock wait gives done for exactly one cycle, with busy low in that same cycle. With ready latency L and lock latency K, done appears 5+L+K edges after the accepting edge.
- R7: If ready is not seen within RDY_TIMEOUT cycles, or lock is not seen within LOCK_TIMEOUT cycles, err goes high and the controller returns to idle without done. A ready or lock seen in the last allowed cycle still succeeds. err clears when the next start is accepted.
- R8: Start requests made while busy are ignored. They change neither the written word nor the timing, and they start no second sequence.
- R9: After reset, busy, done, err, syn_rst, prog_en and prog_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle retune request |
| mult_val | input | 8 | Multiplier factor |
| div_val | input | 8 | Divisor factor |
| prog_rdy | input | 1 | Write-complete return from the port |
| syn_locked | input | 1 | Synthesizer lock status |
| prog_addr | output | ADDR_W | Port address |
| prog_wdata | output | 16 | Port write data |
| prog_en | output | 1 | Port enable strobe |
| prog_we | output | 1 | Port write strobe |
| syn_rst | output | 1 | Synthesizer reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, held until the next accepted start |

## Verification
Every result has a fixed due time, counted from the edge that accepts start. The strobe appears after edge 3. The reset release follows at edge 4+L. done is due at edge 5+L+K. err is due at edge 4+RDY_TIMEOUT for a ready timeout, or at edge 4+L+LOCK_TIMEOUT for a lock timeout. The bench sets L and K in its port model and counts edges from acceptance. It samples each output on the falling edge after the edge where that output is due, and compares against these formulas. The sweeps run L and K across each timeout boundary, and the extra start requests are timed to land in the reset hold and in the lock wait.

// File: rtl/clksynth_retune.sv
module clksynth_retune #(
  parameter int ADDR_W       = 7,
  parameter int CFG_ADDR     = 'h50,
  parameter int RST_HOLD     = 3,
  parameter int RDY_TIMEOUT  = 64,
  parameter int LOCK_TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        mult_val,
  input  logic [7:0]        div_val,
  input  logic              prog_rdy,
  input  logic              syn_locked,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_wdata,
  output logic              prog_en,
  output logic              prog_we,
  output logic              syn_rst,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int LIM   = (RDY_TIMEOUT > LOCK_TIMEOUT) ?
                         ((RDY_TIMEOUT > RST_HOLD) ? RDY_TIMEOUT : RST_HOLD) :
                         ((LOCK_TIMEOUT > RST_HOLD) ? LOCK_TIMEOUT : RST_HOLD);
  localparam int CNT_W = $clog2(LIM + 1);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_WRITE, S_WRDY, S_WLOCK} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      word <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_HOLD;
          cnt  <= '0;
          word <= {mult_val - 8'd1, div_val - 8'd1};
          err  <= 1'b0;
        end
        S_HOLD: if (cnt == CNT_W'(RST_HOLD - 1)) begin
          st  <= S_WRITE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_WRITE: begin
          st  <= S_WRDY;
          cnt <= '0;
        end
        S_WRDY: if (prog_rdy) begin
          st  <= S_WLOCK;
          cnt <= '0;
        end else if (cnt == CNT_W'(RDY_TIMEOUT - 1)) begin
          st  <= S_IDLE;
          err <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_WLOCK: if (syn_locked) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else if (cnt == CNT_W'(LOCK_TIMEOUT - 1)) begin
          st  <= S_IDLE;
          err <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign prog_addr  = ADDR_W'(CFG_ADDR);
  assign prog_wdata = word;
  assign prog_en    = (st == S_WRITE);
  assign prog_we    = (st == S_WRITE);
  assign syn_rst    = (st == S_HOLD) || (st == S_WRITE) || (st == S_WRDY);
  assign busy       = (st != S_IDLE);
endmodule

// File: rtl/clksynth_retune_chk.sv
module clksynth_retune_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        syn_rst,
  input logic        syn_locked,
  input logic        prog_en,
  input logic [15:0] prog_wdata
);
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(prog_wdata)); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && syn_rst); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !syn_rst && !prog_en); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> !prog_en); // R3
  AST_RST_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> syn_rst && $past(syn_rst) && $past(syn_rst, 2) && $past(syn_rst, 3)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(syn_locked) && !busy); // R6
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err); // R7
endmodule

bind clksynth_retune clksynth_retune_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .syn_rst(syn_rst), .syn_locked(syn_locked),
  .prog_en(prog_en), .prog_wdata(prog_wdata)
);

// File: tb/tb_clksynth_retune.sv
`timescale 1ns/1ps
module tb_clksynth_retune;
  localparam int RT = 8;
  localparam int LT = 16;
  localparam int HOLD = 3;
  localparam int ADDR = 'h50;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] mult_val = '0, div_val = '0;
  logic prog_rdy, syn_locked;
  logic [6:0] prog_addr;
  logic [15:0] prog_wdata;
  logic prog_en, prog_we, syn_rst, busy, done, err;

  int total = 0, fails = 0;
  int rdy_lat = 1, lock_lat = 1;
  logic [7:0] rdy_ctr, lk_ctr;

  always #2 clk = ~clk;

  clksynth_retune #(.ADDR_W(7), .CFG_ADDR(ADDR), .RST_HOLD(HOLD),
                    .RDY_TIMEOUT(RT), .LOCK_TIMEOUT(LT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mult_val(mult_val),
    .div_val(div_val), .prog_rdy(prog_rdy), .syn_locked(syn_locked),
    .prog_addr(prog_addr), .prog_wdata(prog_wdata), .prog_en(prog_en),
    .prog_we(prog_we), .syn_rst(syn_rst), .busy(busy), .done(done), .err(err));

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_ctr <= '0;
    else if (prog_en && prog_we) rdy_ctr <= rdy_lat[7:0];
    else if (rdy_ctr != 0) rdy_ctr <= rdy_ctr - 1'b1;
  end
  assign prog_rdy = (rdy_ctr == 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || syn_rst) lk_ctr <= '0;
    else if (lk_ctr < lock_lat[7:0]) lk_ctr <= lk_ctr + 1'b1;
  end
  assign syn_locked = (lk_ctr == lock_lat[7:0]);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] m, input logic [7:0] d,
                     input int l, input int k, input bit poke);
    int kk = 0, en_k = -1, rst_before = 0, end_k = -1;
    int exp_k;
    bit exp_err;
    logic [15:0] w = '0;
    logic [15:0] exp_w = {m - 8'd1, d - 8'd1};
    rdy_lat = l;
    lock_lat = k;
    if (l > RT) begin exp_err = 1; exp_k = 4 + RT; end
    else if (k > LT - 1) begin exp_err = 1; exp_k = 4 + l + LT; end
    else begin exp_err = 0; exp_k = 5 + l + k; end
    @(negedge clk);
    start = 1'b1; mult_val = m; div_val = d;
    @(posedge clk);
    while (kk < 400) begin
      @(negedge clk);
      start = 1'b0;
      if (kk == 0) begin
        chk(busy && syn_rst, "R2 busy/reset after start", {busy, syn_rst}, 3);
        chk(!err, "R7 err cleared on start", err, 0);
      end
      if (l <= RT && kk == 3 + l) chk(syn_rst, "R4 reset held until ready", syn_rst, 1);
      if (l <= RT && kk == 4 + l) chk(!syn_rst, "R5 reset released after ready", syn_rst, 0);
      if (prog_en && en_k < 0) begin
        en_k = kk; w = prog_wdata;
        chk(prog_we, "R3 write strobe with enable", prog_we, 1);
        chk(prog_addr == 7'(ADDR), "R1 address", prog_addr, ADDR);
      end else if (prog_en) chk(0, "R3 second strobe", kk, en_k);
      if (en_k < 0 && syn_rst) rst_before++;
      if (done || err) begin end_k = kk; break; end
      if (poke && (kk == 1 || kk == 4 + l)) begin
        start = 1'b1; mult_val = m ^ 8'h5A; div_val = d ^ 8'hA5;
      end
      @(posedge clk);
      kk++;
    end
    chk(en_k == 3, "R3 strobe cycle", en_k, 3);
    chk(rst_before == HOLD, "R4 reset cycles before write", rst_before, HOLD);
    chk(w == exp_w, "R1 write word", w, exp_w);
    chk(end_k == exp_k, exp_err ? "R7 timeout cycle" : "R6 done cycle", end_k, exp_k);
    chk(err == exp_err, "R7 err flag", err, exp_err);
    chk(done == !exp_err, "R6 done flag", done, !exp_err);
    chk(!busy, "R6 busy low with result", busy, 0);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy && !done && !syn_rst, "R8 no restart / R5 late ready ignored",
          {busy, done, syn_rst}, 0);
    end
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !syn_rst && !prog_en && !prog_we, "R9 reset state",
        {busy, done, err, syn_rst, prog_en, prog_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !syn_rst, "R9 idle after reset", {busy, syn_rst}, 0);
    run(8'd8, 8'd1, 2, 3, 0);
    run(8'd25, 8'd3, 2, 3, 0);
    run(8'd35, 8'd6, 2, 3, 0);
    for (int l = 1; l <= RT + 1; l++) run(8'd20 + 8'(l), 8'd2, l, 2, 0);
    for (int k = 1; k <= LT; k++) run(8'd4, 8'd40 + 8'(k), 1, k, 0);
    run(8'd1, 8'd1, 3, 4, 1);
    run(8'd0, 8'd0, 1, 1, 1);
    run(8'd255, 8'd128, 4, 5, 1);
    run(8'd128, 8'd255, RT, LT - 1, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule